// File: doc/BRIEF.md
# Secure exception routing and trap decoder

This block turns one security configuration word into the decisions a processor core needs at the moment an event or an instruction arrives. Its inputs are the configuration word, the current mode (a Monitor flag and a privileged-kernel flag), and the qualifiers that describe the event or the instruction. Its outputs are:

- where IRQ, FIQ and external aborts are delivered;
- whether a wait-for-event or wait-for-interrupt is trapped to Monitor or suspends normally;
- whether a secure monitor call or a hypervisor call is undefined, trapped or performed;
- whether an instruction fetch is refused;
- whether the asynchronous-abort (A) and fast-interrupt (F) mask bits of the status register may be written.

The block keeps no state, and every output is a pure function of the present inputs. The core samples the outputs in the same cycle in which it presents a candidate event. Because the decoder holds nothing, its outputs follow the inputs at once when the configuration word changes.

Top module: `secure_route_decoder`

## Requirements
- R1: `eff_nonsecure_o` equals configuration bit 0 when `in_monitor_i` is low, and is 0 whenever `in_monitor_i` is high.
- R2: `irq_to_mon_o`, `fiq_to_mon_o` and `abt_to_mon_o` follow configuration bits 1, 2 and 3. A value of 1 sends the event to Monitor, and 0 sends it to its own IRQ, FIQ or Abort mode.
- R3: `wfe_trap_o` is 1 only when all of these hold: `wfe_valid_i` is 1, configuration bit 13 is 1, `in_monitor_i` is 0, and the instruction would suspend. A wait-for-event would suspend when `evt_reg_set_i`, `wfe_wake_pend_i` and `wfx_other_exc_i` are all 0.
- R4: `wfi_trap_o` is 1 only when all of these hold: `wfi_valid_i` is 1, configuration bit 12 is 1, `in_monitor_i` is 0, and the instruction would suspend. A wait-for-interrupt would suspend when `wfi_wake_pend_i` and `wfx_other_exc_i` are both 0.
- R5: `wfe_suspend_o` and `wfi_suspend_o` are 1 when the instruction is valid, would suspend and is not trapped. A trap and a suspend are never signalled together.
- R6: Priority for a valid secure monitor call in effective Non-secure state:
  - If `smc_hyp_trap_i` is set, the call gives `smc_to_hyp_o`.
  - Otherwise, if configuration bit 7 is set, the call gives `smc_undef_o`.
  - Otherwise it gives `smc_exec_o`.
  In effective Secure state a valid call always gives `smc_exec_o`.
- R7: A valid hypervisor call gives `hvc_call_o` when configuration bit 8 is 1, the effective state is Non-secure and `in_pl1_i` is 1. In every other case it gives `hvc_undef_o`.
- R8: `fetch_block_o` is 1 when all of these hold: `fetch_valid_i` is 1, `fetch_ns_target_i` is 1, configuration bit 9 is 1, and the effective state is Secure.
- R9: `a_mask_wr_ok_o` is 1 in effective Secure state or when configuration bit 5 is 1. `f_mask_wr_ok_o` is 1 in effective Secure state or when configuration bit 4 is 1.
- R10: Configuration bits 6, 10, 11 and 14 and above have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sec_cfg_i | input | CFG_W | Security configuration word |
| in_monitor_i | input | 1 | Core is in Monitor mode |
| in_pl1_i | input | 1 | Core is in a privileged kernel mode (not Monitor, not Hyp) |
| wfe_valid_i | input | 1 | Wait-for-event is executing |
| evt_reg_set_i | input | 1 | Event register is set |
| wfe_wake_pend_i | input | 1 | Wait-for-event wakeup is pending |
| wfi_valid_i | input | 1 | Wait-for-interrupt is executing |
| wfi_wake_pend_i | input | 1 | Wait-for-interrupt wakeup is pending |
| wfx_other_exc_i | input | 1 | The wait instruction raises another exception |
| smc_valid_i | input | 1 | Secure monitor call is executing |
| smc_hyp_trap_i | input | 1 | Hypervisor trap of the monitor call is enabled |
| hvc_valid_i | input | 1 | Hypervisor call is executing |
| fetch_valid_i | input | 1 | Instruction fetch request |
| fetch_ns_target_i | input | 1 | Fetch targets Non-secure memory |
| eff_nonsecure_o | output | 1 | Effective security state, 1 for Non-secure |
| irq_to_mon_o | output | 1 | IRQ goes to Monitor |
| fiq_to_mon_o | output | 1 | FIQ goes to Monitor |
| abt_to_mon_o | output | 1 | External abort goes to Monitor |
| wfe_trap_o | output | 1 | Wait-for-event trapped to Monitor as undefined |
| wfe_suspend_o | output | 1 | Wait-for-event suspends |
| wfi_trap_o | output | 1 | Wait-for-interrupt trapped to Monitor as undefined |
| wfi_suspend_o | output | 1 | Wait-for-interrupt suspends |
| smc_to_hyp_o | output | 1 | Monitor call trapped to Hyp |
| smc_undef_o | output | 1 | Monitor call undefined |
| smc_exec_o | output | 1 | Monitor call performed |
| hvc_call_o | output | 1 | Hypervisor call performed |
| hvc_undef_o | output | 1 | Hypervisor call undefined |
| fetch_block_o | output | 1 | Fetch refused |
| a_mask_wr_ok_o | output | 1 | A mask bit writable |
| f_mask_wr_ok_o | output | 1 | F mask bit writable |

## Verification
The bench builds the decoder with the default 32-bit configuration word. That width brings the reserved field above bit 13 within reach, along with the unused bits inside the low half. Each scenario sweeps every combination of the inputs it depends on. In every sweep the reserved bits carry random values, so any dependence on them shows up as a mismatch in a normal decision. Monitor mode is crossed with the Non-secure bit in every sweep, which tests the security override together with each trap and routing rule.

// File: rtl/secure_route_decoder.sv
module secure_route_decoder #(
  parameter int CFG_W = 32
) (
  input  logic [CFG_W-1:0] sec_cfg_i,
  input  logic             in_monitor_i,
  input  logic             in_pl1_i,
  input  logic             wfe_valid_i,
  input  logic             evt_reg_set_i,
  input  logic             wfe_wake_pend_i,
  input  logic             wfi_valid_i,
  input  logic             wfi_wake_pend_i,
  input  logic             wfx_other_exc_i,
  input  logic             smc_valid_i,
  input  logic             smc_hyp_trap_i,
  input  logic             hvc_valid_i,
  input  logic             fetch_valid_i,
  input  logic             fetch_ns_target_i,
  output logic             eff_nonsecure_o,
  output logic             irq_to_mon_o,
  output logic             fiq_to_mon_o,
  output logic             abt_to_mon_o,
  output logic             wfe_trap_o,
  output logic             wfe_suspend_o,
  output logic             wfi_trap_o,
  output logic             wfi_suspend_o,
  output logic             smc_to_hyp_o,
  output logic             smc_undef_o,
  output logic             smc_exec_o,
  output logic             hvc_call_o,
  output logic             hvc_undef_o,
  output logic             fetch_block_o,
  output logic             a_mask_wr_ok_o,
  output logic             f_mask_wr_ok_o
);
  localparam int B_NS  = 0;
  localparam int B_IRQ = 1;
  localparam int B_FIQ = 2;
  localparam int B_EA  = 3;
  localparam int B_FW  = 4;
  localparam int B_AW  = 5;
  localparam int B_SMD = 7;
  localparam int B_HVE = 8;
  localparam int B_SIF = 9;
  localparam int B_TWI = 12;
  localparam int B_TWE = 13;

  logic ns_eff;
  logic wfe_would_sleep, wfi_would_sleep;
  logic smc_ns;

  assign ns_eff = sec_cfg_i[B_NS] & ~in_monitor_i;
  assign eff_nonsecure_o = ns_eff;

  assign irq_to_mon_o = sec_cfg_i[B_IRQ];
  assign fiq_to_mon_o = sec_cfg_i[B_FIQ];
  assign abt_to_mon_o = sec_cfg_i[B_EA];

  assign wfe_would_sleep = wfe_valid_i & ~evt_reg_set_i & ~wfe_wake_pend_i & ~wfx_other_exc_i;
  assign wfi_would_sleep = wfi_valid_i & ~wfi_wake_pend_i & ~wfx_other_exc_i;

  assign wfe_trap_o    = wfe_would_sleep & sec_cfg_i[B_TWE] & ~in_monitor_i;
  assign wfi_trap_o    = wfi_would_sleep & sec_cfg_i[B_TWI] & ~in_monitor_i;
  assign wfe_suspend_o = wfe_would_sleep & ~wfe_trap_o;
  assign wfi_suspend_o = wfi_would_sleep & ~wfi_trap_o;

  assign smc_ns       = smc_valid_i & ns_eff;
  assign smc_to_hyp_o = smc_ns & smc_hyp_trap_i;
  assign smc_undef_o  = smc_ns & ~smc_hyp_trap_i & sec_cfg_i[B_SMD];
  assign smc_exec_o   = smc_valid_i & ~smc_to_hyp_o & ~smc_undef_o;

  assign hvc_call_o  = hvc_valid_i & sec_cfg_i[B_HVE] & ns_eff & in_pl1_i;
  assign hvc_undef_o = hvc_valid_i & ~hvc_call_o;

  assign fetch_block_o = fetch_valid_i & fetch_ns_target_i & sec_cfg_i[B_SIF] & ~ns_eff;

  assign a_mask_wr_ok_o = ~ns_eff | sec_cfg_i[B_AW];
  assign f_mask_wr_ok_o = ~ns_eff | sec_cfg_i[B_FW];
endmodule

// File: rtl/secure_route_chk.sv
module secure_route_chk #(
  parameter int CFG_W = 32
) (
  input logic [CFG_W-1:0] sec_cfg_i,
  input logic in_monitor_i,
  input logic in_pl1_i,
  input logic wfe_valid_i,
  input logic wfi_valid_i,
  input logic smc_valid_i,
  input logic hvc_valid_i,
  input logic eff_nonsecure_o,
  input logic wfe_trap_o,
  input logic wfe_suspend_o,
  input logic wfi_trap_o,
  input logic wfi_suspend_o,
  input logic smc_to_hyp_o,
  input logic smc_undef_o,
  input logic smc_exec_o,
  input logic hvc_call_o,
  input logic hvc_undef_o,
  input logic fetch_block_o,
  input logic a_mask_wr_ok_o,
  input logic f_mask_wr_ok_o
);
  always_comb begin
    // R1
    monitor_secure_chk: assert (!in_monitor_i || !eff_nonsecure_o);
    // R3
    wfe_no_mon_trap_chk: assert (!wfe_trap_o || (!in_monitor_i && wfe_valid_i));
    // R4
    wfi_no_mon_trap_chk: assert (!wfi_trap_o || (!in_monitor_i && wfi_valid_i));
    // R5
    wfx_exclusive_chk: assert (!(wfe_trap_o && wfe_suspend_o) && !(wfi_trap_o && wfi_suspend_o));
    // R6
    smc_onehot_chk: assert (smc_valid_i ? $countones({smc_to_hyp_o, smc_undef_o, smc_exec_o}) == 1
                                        : !(smc_to_hyp_o || smc_undef_o || smc_exec_o));
    // R6
    smc_secure_exec_chk: assert (!(smc_undef_o || smc_to_hyp_o) || eff_nonsecure_o);
    // R7
    hvc_call_chk: assert (!hvc_call_o || (eff_nonsecure_o && in_pl1_i && !hvc_undef_o));
    // R8
    fetch_secure_only_chk: assert (!fetch_block_o || !eff_nonsecure_o);
    // R9
    mask_secure_ok_chk: assert (eff_nonsecure_o || (a_mask_wr_ok_o && f_mask_wr_ok_o));
  end
endmodule

bind secure_route_decoder secure_route_chk #(.CFG_W(CFG_W)) u_chk (.*);

// File: tb/secure_route_decoder_tb.sv
module secure_route_decoder_tb;
  localparam int CFG_W = 32;
  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic [CFG_W-1:0] cfg;
  logic mon, pl1, wfe_v, evt, wfe_wk, wfi_v, wfi_wk, oexc, smc_v, smc_ht, hvc_v, f_v, f_ns;
  logic ns_o, irq_o, fiq_o, abt_o, wfe_t, wfe_s, wfi_t, wfi_s, smc_h, smc_u, smc_e, hvc_c, hvc_u, fb_o, a_ok, f_ok;

  int n_run = 0, n_fail = 0, cyc = 0;

  secure_route_decoder #(.CFG_W(CFG_W)) u_dut (
    .sec_cfg_i(cfg), .in_monitor_i(mon), .in_pl1_i(pl1),
    .wfe_valid_i(wfe_v), .evt_reg_set_i(evt), .wfe_wake_pend_i(wfe_wk),
    .wfi_valid_i(wfi_v), .wfi_wake_pend_i(wfi_wk), .wfx_other_exc_i(oexc),
    .smc_valid_i(smc_v), .smc_hyp_trap_i(smc_ht), .hvc_valid_i(hvc_v),
    .fetch_valid_i(f_v), .fetch_ns_target_i(f_ns),
    .eff_nonsecure_o(ns_o), .irq_to_mon_o(irq_o), .fiq_to_mon_o(fiq_o), .abt_to_mon_o(abt_o),
    .wfe_trap_o(wfe_t), .wfe_suspend_o(wfe_s), .wfi_trap_o(wfi_t), .wfi_suspend_o(wfi_s),
    .smc_to_hyp_o(smc_h), .smc_undef_o(smc_u), .smc_exec_o(smc_e),
    .hvc_call_o(hvc_c), .hvc_undef_o(hvc_u), .fetch_block_o(fb_o),
    .a_mask_wr_ok_o(a_ok), .f_mask_wr_ok_o(f_ok)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b cfg=%h mon=%b", req, act, exp, cfg, mon);
    end
  endtask

  function automatic logic [CFG_W-1:0] rsv_noise();
    logic [CFG_W-1:0] r;
    r = {$urandom, $urandom};
    r[13:12] = 2'b0; r[9:7] = 3'b0; r[5:0] = 6'b0;
    return r;
  endfunction

  task automatic idle();
    cfg = '0; mon = 0; pl1 = 0; wfe_v = 0; evt = 0; wfe_wk = 0; wfi_v = 0; wfi_wk = 0;
    oexc = 0; smc_v = 0; smc_ht = 0; hvc_v = 0; f_v = 0; f_ns = 0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    idle(); settle();
    chk("R1 reset ns", ns_o, 0);
    chk("R2 reset route", irq_o | fiq_o | abt_o, 0);
    chk("R5 reset wfx", wfe_t | wfe_s | wfi_t | wfi_s, 0);
    chk("R6 reset smc", smc_h | smc_u | smc_e, 0);
    chk("R7 reset hvc", hvc_c | hvc_u, 0);
    chk("R8 reset fetch", fb_o, 0);
    chk("R9 reset masks", a_ok & f_ok, 1);
  endtask

  task automatic t_state_route();
    for (int i = 0; i < 64; i++) begin
      idle();
      cfg = rsv_noise();
      cfg[0] = i[0]; cfg[1] = i[1]; cfg[2] = i[2]; cfg[3] = i[3];
      mon = i[4];
      settle();
      chk("R1 eff ns", ns_o, i[0] & ~i[4]);
      chk("R2 irq", irq_o, i[1]);
      chk("R2 fiq", fiq_o, i[2]);
      chk("R2 abt", abt_o, i[3]);
    end
  endtask

  task automatic t_wfx();
    for (int i = 0; i < 512; i++) begin
      logic sl_e, sl_i;
      idle();
      cfg = rsv_noise();
      cfg[13] = i[0]; cfg[12] = i[1]; mon = i[2]; wfe_v = i[3]; wfi_v = i[4];
      evt = i[5]; wfe_wk = i[6]; wfi_wk = i[7]; oexc = i[8];
      cfg[0] = i[5];
      settle();
      sl_e = i[3] & ~i[5] & ~i[6] & ~i[8];
      sl_i = i[4] & ~i[7] & ~i[8];
      chk("R3 wfe trap", wfe_t, sl_e & i[0] & ~i[2]);
      chk("R4 wfi trap", wfi_t, sl_i & i[1] & ~i[2]);
      chk("R5 wfe suspend", wfe_s, sl_e & ~(i[0] & ~i[2]));
      chk("R5 wfi suspend", wfi_s, sl_i & ~(i[1] & ~i[2]));
    end
  endtask

  task automatic t_calls();
    for (int i = 0; i < 128; i++) begin
      logic nse, hyp, und;
      idle();
      cfg = rsv_noise();
      cfg[0] = i[0]; mon = i[1]; cfg[7] = i[2]; smc_ht = i[3]; smc_v = i[4];
      cfg[8] = i[5]; pl1 = i[6]; hvc_v = i[4];
      settle();
      nse = i[0] & ~i[1];
      hyp = i[4] & nse & i[3];
      und = i[4] & nse & ~i[3] & i[2];
      chk("R6 smc hyp", smc_h, hyp);
      chk("R6 smc undef", smc_u, und);
      chk("R6 smc exec", smc_e, i[4] & ~hyp & ~und);
      chk("R7 hvc call", hvc_c, i[4] & i[5] & nse & i[6]);
      chk("R7 hvc undef", hvc_u, i[4] & ~(i[5] & nse & i[6]));
    end
  endtask

  task automatic t_fetch_masks();
    for (int i = 0; i < 128; i++) begin
      logic nse;
      idle();
      cfg = rsv_noise();
      cfg[0] = i[0]; mon = i[1]; cfg[9] = i[2]; f_v = i[3]; f_ns = i[4];
      cfg[5] = i[5]; cfg[4] = i[6];
      settle();
      nse = i[0] & ~i[1];
      chk("R8 fetch block", fb_o, i[3] & i[4] & i[2] & ~nse);
      chk("R9 a mask", a_ok, ~nse | i[5]);
      chk("R9 f mask", f_ok, ~nse | i[6]);
    end
  endtask

  task automatic t_reserved();
    for (int i = 0; i < 32; i++) begin
      idle();
      cfg = '0; cfg[0] = 1; pl1 = 1; hvc_v = 1; smc_v = 1; wfe_v = 1; wfi_v = 1; f_v = 1; f_ns = 1;
      cfg = cfg | rsv_noise();
      if (i == 0) cfg[CFG_W-1:14] = '1;
      if (i == 1) cfg[11:10] = 2'b11;
      if (i == 2) cfg[6] = 1'b1;
      settle();
      chk("R10 rsv route", irq_o | fiq_o | abt_o, 0);
      chk("R10 rsv wfx", wfe_t | wfi_t, 0);
      chk("R10 rsv suspend", wfe_s & wfi_s, 1);
      chk("R10 rsv smc", smc_e, 1);
      chk("R10 rsv hvc", hvc_u, 1);
      chk("R10 rsv fetch", fb_o, 0);
      chk("R10 rsv masks", a_ok | f_ok, 0);
    end
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    rst_n = 1;
    t_reset_state();
    t_state_route();
    t_wfx();
    t_calls();
    t_fetch_masks();
    t_reserved();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule